// File: doc/BRIEF.md
# Coherent Transaction Policy Classifier

This block sits in the request path of an address translation unit placed in front of an ACE-family master. Each incoming read or write request carries an opcode, a shareability domain and a flag that asks for an address-translation-service lookup. The block classifies the request into one behaviour code that tells the downstream stages how to treat it. The code can mean translate, translate with a no-shareable check, translate with a protection-only check, pass through unmodified, abort with a slave error, or protocol-illegal.

The decision does not come from the opcode alone. It also depends on the shareability domain, on whether the port is set up as a fully coherent interface or as a lite interface, and on a bit that disables cache maintenance. The code is registered together with the request's opcode, address and identifier in a single output stage with valid/ready handshaking. The translation walk, the checks on the translation result and the error responses belong to other blocks.

Top module: `coh_policy_classifier`

## Requirements
- R1: While and after reset, out_valid is 0 and in_ready is 1.
- R2: When cfg_full is 1, a request with in_ats set is classified abort (code 4) whatever its opcode. When cfg_full is 0, in_ats has no effect on the code.
- R3: Opcodes 0 to 4 (no-snoop read, read-once, no-snoop write, write-unique, write-line-unique) give translate (code 0) when cfg_full is 0 and translate-no-shareable (code 1) when cfg_full is 1.
- R4: Opcodes 5 to 10 (clean, not-shared-dirty, shared and unique reads, clean-unique, make-unique) give illegal (code 5) when cfg_full is 0 and protection-only (code 2) when cfg_full is 1.
- R5: Opcodes 11 to 13 (write-back, write-clean, write-evict) give illegal when cfg_full is 0. When cfg_full is 1 they give abort if in_domain is 0 (non-shareable) and pass-through (code 3) if in_domain is nonzero. Opcode 14 (evict) gives illegal in lite and pass-through in full.
- R6: Opcodes 15 to 18 (clean-shared, clean-shared-persist, clean-invalid, make-invalid) always give abort when cfg_full is 1. When cfg_full is 0 they give translate if cmo_dis is 0 and abort if cmo_dis is 1.
- R7: Opcodes 19 to 25 (read-once with clean or make invalidate, partial and full stash writes, the two stash-once requests, stash-translation) give translate in lite and illegal in full.
- R8: Opcode 26 (barrier completion) gives illegal in lite and pass-through in full. Opcode 27 (barrier message) gives illegal in lite and abort in full.
- R9: Opcodes 28 to 31 give illegal in both configurations. Codes 6 and 7 are never produced.
- R10: While out_valid is 1 and out_ready is 0, out_code, out_opcode, out_addr and out_id hold their values.
- R11: A request is captured only on a cycle with in_valid and in_ready both 1. in_ready is 1 when the output stage is empty or is being drained, and the captured address and id appear on the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full | input | 1 | 1 = fully coherent interface, 0 = lite interface |
| cmo_dis | input | 1 | Cache maintenance disable (lite configuration only) |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_opcode | input | 5 | Transaction opcode |
| in_domain | input | 2 | Shareability domain, 0 = non-shareable |
| in_ats | input | 1 | Translation-service request flag |
| in_addr | input | ADDR_W | Request address |
| in_id | input | ID_W | Request identifier |
| out_valid | output | 1 | Classified request valid |
| out_ready | input | 1 | Downstream ready |
| out_code | output | 3 | Behaviour code |
| out_opcode | output | 5 | Registered opcode |
| out_addr | output | ADDR_W | Registered address |
| out_id | output | ID_W | Registered identifier |

## Verification
Two things can happen in the same cycle: a held result is drained and a new request is captured into the stage that is being freed. The bench provokes this by stalling the output with a protection-only result while a second request waits at the input with in_ready low. It then raises out_ready on a single edge. The run passes if the stalled values stay stable during the stall and, one cycle after the release, the outputs carry the second request's code, address and id with out_valid still high and no gap.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int OPC_W = 5;
  localparam int DOM_W = 2;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    BHV_XLATE      = 3'd0,
    BHV_XLATE_NOSH = 3'd1,
    BHV_PROT       = 3'd2,
    BHV_PASS       = 3'd3,
    BHV_ABORT      = 3'd4,
    BHV_ILLEGAL    = 3'd5
  } bhv_e;

  typedef enum logic [3:0] {
    GRP_IO,
    GRP_COH,
    GRP_WB_NSH,
    GRP_WB_SH,
    GRP_CMO,
    GRP_STASH,
    GRP_BAR_CMPL,
    GRP_BAR_MSG,
    GRP_UNKNOWN
  } grp_e;

  // opcode map: group boundaries are decoded by range
  localparam logic [OPC_W-1:0] OP_IO_LO    = 5'd0;
  localparam logic [OPC_W-1:0] OP_IO_HI    = 5'd4;
  localparam logic [OPC_W-1:0] OP_COH_LO   = 5'd5;
  localparam logic [OPC_W-1:0] OP_COH_HI   = 5'd10;
  localparam logic [OPC_W-1:0] OP_WB_LO    = 5'd11;
  localparam logic [OPC_W-1:0] OP_WB_HI    = 5'd13;
  localparam logic [OPC_W-1:0] OP_EVICT    = 5'd14;
  localparam logic [OPC_W-1:0] OP_CMO_LO   = 5'd15;
  localparam logic [OPC_W-1:0] OP_CMO_HI   = 5'd18;
  localparam logic [OPC_W-1:0] OP_STASH_LO = 5'd19;
  localparam logic [OPC_W-1:0] OP_STASH_HI = 5'd25;
  localparam logic [OPC_W-1:0] OP_BAR_CMPL = 5'd26;
  localparam logic [OPC_W-1:0] OP_BAR_MSG  = 5'd27;
endpackage

// File: rtl/cpc_group_decode.sv
module cpc_group_decode
  import cpc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [DOM_W-1:0] domain,
  output grp_e             grp
);
  logic shareable;
  assign shareable = (domain != '0);

  always_comb begin
    if (opcode <= OP_IO_HI)
      grp = GRP_IO;
    else if (opcode >= OP_COH_LO && opcode <= OP_COH_HI)
      grp = GRP_COH;
    else if (opcode >= OP_WB_LO && opcode <= OP_WB_HI)
      grp = shareable ? GRP_WB_SH : GRP_WB_NSH;
    else if (opcode == OP_EVICT)
      grp = GRP_WB_SH;
    else if (opcode >= OP_CMO_LO && opcode <= OP_CMO_HI)
      grp = GRP_CMO;
    else if (opcode >= OP_STASH_LO && opcode <= OP_STASH_HI)
      grp = GRP_STASH;
    else if (opcode == OP_BAR_CMPL)
      grp = GRP_BAR_CMPL;
    else if (opcode == OP_BAR_MSG)
      grp = GRP_BAR_MSG;
    else
      grp = GRP_UNKNOWN;
  end
endmodule

// File: rtl/cpc_policy_map.sv
module cpc_policy_map
  import cpc_pkg::*;
(
  input  grp_e  grp,
  input  logic  cfg_full,
  input  logic  cmo_dis,
  input  logic  ats,
  output bhv_e  code
);
  bhv_e lite_code;
  bhv_e full_code;

  always_comb begin
    case (grp)
      GRP_IO:    lite_code = BHV_XLATE;
      GRP_CMO:   lite_code = cmo_dis ? BHV_ABORT : BHV_XLATE;
      GRP_STASH: lite_code = BHV_XLATE;
      default:   lite_code = BHV_ILLEGAL;
    endcase
  end

  always_comb begin
    case (grp)
      GRP_IO:       full_code = BHV_XLATE_NOSH;
      GRP_COH:      full_code = BHV_PROT;
      GRP_WB_NSH:   full_code = BHV_ABORT;
      GRP_WB_SH:    full_code = BHV_PASS;
      GRP_CMO:      full_code = BHV_ABORT;
      GRP_BAR_CMPL: full_code = BHV_PASS;
      GRP_BAR_MSG:  full_code = BHV_ABORT;
      default:      full_code = BHV_ILLEGAL;
    endcase
  end

  always_comb begin
    if (!cfg_full)
      code = lite_code;
    else if (ats)
      code = BHV_ABORT;
    else
      code = full_code;
  end
endmodule

// File: rtl/cpc_out_stage.sv
module cpc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready)
      data_q <= in_data;
  end
endmodule

// File: rtl/coh_policy_classifier.sv
module coh_policy_classifier
  import cpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_full,
  input  logic              cmo_dis,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [DOM_W-1:0]  in_domain,
  input  logic              in_ats,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ID_W-1:0]   out_id
);
  localparam int PL_W = CODE_W + OPC_W + ADDR_W + ID_W;

  grp_e            grp;
  bhv_e            code;
  logic [PL_W-1:0] pl_d;
  logic [PL_W-1:0] pl_q;

  cpc_group_decode u_grp (
    .opcode (in_opcode),
    .domain (in_domain),
    .grp    (grp)
  );

  cpc_policy_map u_map (
    .grp      (grp),
    .cfg_full (cfg_full),
    .cmo_dis  (cmo_dis),
    .ats      (in_ats),
    .code     (code)
  );

  assign pl_d = {code, in_opcode, in_addr, in_id};

  cpc_out_stage #(.W(PL_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pl_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pl_q)
  );

  assign {out_code, out_opcode, out_addr, out_id} = pl_q;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_full,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_opcode,
  input logic              in_ats,
  input logic [ADDR_W-1:0] in_addr,
  input logic [ID_W-1:0]   in_id,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_code,
  input logic [4:0]        out_opcode,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ID_W-1:0]   out_id
);
  // R2: full configuration with translation-service flag aborts
  a_r2_ats_abort: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cfg_full && in_ats) |=> (out_code == 3'd4));

  // R3: I/O group translates in lite
  a_r3_io_lite: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !cfg_full && in_opcode <= 5'd4) |=> (out_code == 3'd0));

  // R9: only defined codes reach the output
  a_r9_code_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code <= 3'd5));

  // R10: stalled output is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_opcode)
                                   && $stable(out_addr) && $stable(out_id)));

  // R11: a captured request appears on the next cycle
  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr) && out_id == $past(in_id)));
endmodule

bind coh_policy_classifier cpc_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/coh_policy_classifier_tb.sv
`timescale 1ns/1ps
module coh_policy_classifier_tb;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_full = 1'b0;
  logic              cmo_dis = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [4:0]        in_opcode = '0;
  logic [1:0]        in_domain = '0;
  logic              in_ats = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [ID_W-1:0]   in_id = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [2:0]        out_code;
  logic [4:0]        out_opcode;
  logic [ADDR_W-1:0] out_addr;
  logic [ID_W-1:0]   out_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coh_policy_classifier #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [4:0] op, input logic [1:0] dom, input logic ats,
                      input logic full, input logic cmo, input logic [2:0] exp, input string req);
    logic [ADDR_W-1:0] a;
    a = $urandom;
    @(negedge clk);
    cfg_full = full; cmo_dis = cmo; out_ready = 1'b1;
    in_valid = 1'b1; in_opcode = op; in_domain = dom; in_ats = ats;
    in_addr = a; in_id = op[3:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R11 valid", out_valid, 1);
    chk(out_code == exp, req, out_code, exp);
    chk(out_addr == a && out_id == op[3:0], "R11 payload", out_addr, a);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_io();
    for (int op = 0; op <= 4; op++) begin
      xfer(op[4:0], 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R3 lite");
      xfer(op[4:0], 2'd1, 1'b0, 1'b1, 1'b0, 3'd1, "R3 full");
    end
  endtask

  task automatic t_coh();
    for (int op = 5; op <= 10; op++) begin
      xfer(op[4:0], 2'd1, 1'b0, 1'b0, 1'b0, 3'd5, "R4 lite");
      xfer(op[4:0], 2'd2, 1'b0, 1'b1, 1'b0, 3'd2, "R4 full");
    end
  endtask

  task automatic t_wb();
    for (int op = 11; op <= 13; op++) begin
      xfer(op[4:0], 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R5 lite");
      xfer(op[4:0], 2'd0, 1'b0, 1'b1, 1'b0, 3'd4, "R5 full nsh");
      for (int d = 1; d <= 3; d++)
        xfer(op[4:0], d[1:0], 1'b0, 1'b1, 1'b0, 3'd3, "R5 full sh");
    end
    xfer(5'd14, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R5 evict lite");
    xfer(5'd14, 2'd1, 1'b0, 1'b1, 1'b0, 3'd3, "R5 evict full");
  endtask

  task automatic t_cmo();
    for (int op = 15; op <= 18; op++) begin
      xfer(op[4:0], 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, "R6 lite en");
      xfer(op[4:0], 2'd1, 1'b0, 1'b0, 1'b1, 3'd4, "R6 lite dis");
      xfer(op[4:0], 2'd1, 1'b0, 1'b1, 1'b0, 3'd4, "R6 full");
      xfer(op[4:0], 2'd1, 1'b0, 1'b1, 1'b1, 3'd4, "R6 full dis");
    end
  endtask

  task automatic t_stash();
    for (int op = 19; op <= 25; op++) begin
      xfer(op[4:0], 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, "R7 lite");
      xfer(op[4:0], 2'd1, 1'b0, 1'b1, 1'b0, 3'd5, "R7 full");
    end
  endtask

  task automatic t_barrier();
    xfer(5'd26, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R8 cmpl lite");
    xfer(5'd26, 2'd0, 1'b0, 1'b1, 1'b0, 3'd3, "R8 cmpl full");
    xfer(5'd27, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R8 msg lite");
    xfer(5'd27, 2'd0, 1'b0, 1'b1, 1'b0, 3'd4, "R8 msg full");
  endtask

  task automatic t_unknown();
    for (int op = 28; op <= 31; op++) begin
      xfer(op[4:0], 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R9 lite");
      xfer(op[4:0], 2'd3, 1'b0, 1'b1, 1'b1, 3'd5, "R9 full");
    end
  endtask

  task automatic t_ats();
    xfer(5'd0,  2'd0, 1'b1, 1'b1, 1'b0, 3'd4, "R2 full io");
    xfer(5'd5,  2'd1, 1'b1, 1'b1, 1'b0, 3'd4, "R2 full coh");
    xfer(5'd11, 2'd1, 1'b1, 1'b1, 1'b0, 3'd4, "R2 full wb");
    xfer(5'd30, 2'd0, 1'b1, 1'b1, 1'b0, 3'd4, "R2 full unknown");
    xfer(5'd0,  2'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R2 lite ignored");
    xfer(5'd5,  2'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R2 lite ignored coh");
  endtask

  task automatic t_stall();
    @(negedge clk);
    cfg_full = 1'b1; cmo_dis = 1'b0; out_ready = 1'b0;
    in_valid = 1'b1; in_opcode = 5'd7; in_domain = 2'd1; in_ats = 1'b0;
    in_addr = 32'h1234_5678; in_id = 4'h3;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_code == 3'd2, "R11 first load", out_code, 2);
    in_opcode = 5'd2; in_addr = 32'hCAFE_0040; in_id = 4'h9;
    chk(in_ready == 1'b0, "R11 ready low while stalled", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R10 valid held", out_valid, 1);
      chk(out_code == 3'd2, "R10 code held", out_code, 2);
      chk(out_addr == 32'h1234_5678 && out_id == 4'h3 && out_opcode == 5'd7,
          "R10 payload held", out_addr, 32'h1234_5678);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R11 back-to-back valid", out_valid, 1);
    chk(out_code == 3'd1, "R11 back-to-back code", out_code, 1);
    chk(out_addr == 32'hCAFE_0040 && out_id == 4'h9, "R11 back-to-back payload", out_addr, 32'hCAFE_0040);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_io();
    t_coh();
    t_wb();
    t_cmo();
    t_stash();
    t_barrier();
    t_unknown();
    t_ats();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule